// File: doc/BRIEF.md
# Pipeline Hazard Interlock

This unit guards the decode stage of an eight-stage in-order integer pipeline. The stages are fetch, decode, register read, two ALU stages, two memory stages and register write. Register read and register write each take a whole cycle, so a value being written cannot be read in that same cycle. In every cycle the unit compares the two source operands of the instruction in decode with the destinations of the older instructions still in flight. It raises a stall while any needed value cannot yet be read or forwarded. While the stall is high, fetch and decode hold their contents and an empty slot moves on into register read.

The unit keeps its own record of the tags of the six stages that follow decode: valid, destination and instruction class. It loads the decode tag into that record whenever an instruction leaves decode. The stages behind decode never stall, so the record moves forward by one stage every cycle. A static bypass input picks between a machine that only reads the register file and one with forwarding paths. When forwarding is on, the unit also gives each operand a forwarding-source code: the stage the producer will occupy when the consumer needs the value.

An operand's role sets the stage at which it is consumed. An execute operand and a store's data operand are consumed in the first ALU stage, and a store's address-side operand in the first memory stage. With forwarding, an ALU result can be forwarded once its producer reaches the first memory stage, and a load result once its producer reaches the write stage. Without forwarding, every operand is read in register read, after the producer has left the write stage. The stall in any cycle is the OR over all producers and both operands, so the number of empty slots is the largest distance any of them requires.

Top module: `ilk_interlock`

## Requirements
- R1: After reset the in-flight record is empty: a valid decode instruction with any sources sees stall 0 and forwarding codes 0.
- R2: With bypass_en 0, a consumer waits until its producer has left the write stage. The adjacent dependent instruction gets 5 empty slots, whatever the classes and roles. With one independent instruction between the two it gets 4. Every forwarding code at issue is 0.
- R3: With bypass_en 1, an execute operand (role 1) fed by the ALU instruction (class 1) just before it gets 1 empty slot. That operand's forwarding code is 5 (first memory stage). Code 0 means the register file, and codes 6 and 7 mean the second memory stage and the write stage.
- R4: With bypass_en 1, an execute operand or a store-data operand (role 2) fed by the load (class 2) just before it gets 3 empty slots, with forwarding code 7.
- R5: A store-address operand (role 3) is consumed in the first memory stage. With bypass_en 1, fed by the load just before it, it gets 1 empty slot and forwarding code 7. Fed by the ALU instruction just before it, it gets no empty slot and forwarding code 6.
- R6: None of these creates a dependence: register 0, an operand with role 0 (unused), or a producer of class 0 (none) or class 3 (store), whatever its destination field holds.
- R7: A decode instruction of class 1 or 2 with a nonzero destination equal to that of an older writer still in register read or the first ALU stage is held until that writer reaches the second ALU stage. The adjacent case gives 2 empty slots in either bypass mode.
- R8: The stall is the OR over all in-flight producers and both operands, so the slot count is the largest single need. Each operand's forwarding code comes from its youngest matching producer.
- R9: Each stall cycle holds the decode instruction and sends one empty slot forward. The held instruction then issues exactly once, and the positions of later producers reflect the empty slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bypass_en | input | 1 | Static: 1 enables forwarding paths |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_class | input | 2 | Decode class: 0 none, 1 ALU, 2 load, 3 store |
| dec_dst | input | REG_W | Decode destination register |
| src_a | input | REG_W | First source register |
| role_a | input | 2 | First source role: 0 unused, 1 execute, 2 store data, 3 store address |
| src_b | input | REG_W | Second source register |
| role_b | input | 2 | Second source role, same encoding |
| stall | output | 1 | Hold fetch and decode, send an empty slot forward |
| fwd_a | output | 3 | Forwarding-source code for the first source |
| fwd_b | output | 3 | Forwarding-source code for the second source |

## Verification
Instruction pairs are replayed in both bypass modes: ALU to ALU, load to execute operand, load to store data and load to store address. These separate the three consumption points and the two ready points from each other, and against the flat five-slot case of the machine without forwarding. An ALU producer feeding a store address shows that the later consumption point also removes the stall entirely. Pairs with register 0, an unused role and a store producer show that false matches are ignored. Two same-destination writers isolate the write-after-write hold. Sequences of three instructions check the effect of distance and the maximum over producers, where the empty slots of an earlier stall move the producers.

// File: rtl/ilk_pkg.sv
package ilk_pkg;

    // Stage numbering used for distance arithmetic
    localparam int ST_DE   = 1;
    localparam int ST_RR   = 2;
    localparam int ST_A1   = 3;
    localparam int ST_A2   = 4;
    localparam int ST_M1   = 5;
    localparam int ST_M2   = 6;
    localparam int ST_RW   = 7;
    localparam int ST_GONE = 8;

    // Tracked stages after decode, and the stage an older writer must reach
    localparam int NTRK      = ST_RW - ST_RR + 1;
    localparam int WAW_CLEAR = ST_A2;
    localparam int MAX_RUN   = ST_RW - ST_DE;

    typedef enum logic [1:0] {CL_NONE = 2'd0, CL_ALU = 2'd1, CL_LOAD = 2'd2, CL_STORE = 2'd3} iclass_e;
    typedef enum logic [1:0] {RO_UNUSED = 2'd0, RO_EXEC = 2'd1, RO_SDATA = 2'd2, RO_SADDR = 2'd3} role_e;

    // Stage a producer must occupy for the consumer to pick the value up
    function automatic int ready_at(input logic [1:0] cls, input logic byp);
        if (!byp)
            return ST_GONE;
        return (cls == CL_LOAD) ? ST_RW : ST_M1;
    endfunction

    // Stage at which an operand of the given role is consumed
    function automatic int need_at(input logic [1:0] role, input logic byp);
        if (!byp)
            return ST_RR;
        return (role == RO_SADDR) ? ST_M1 : ST_A1;
    endfunction

    function automatic logic is_writer(input logic [1:0] cls);
        return (cls == CL_ALU) || (cls == CL_LOAD);
    endfunction

endpackage

// File: rtl/ilk_tag_pipe.sv
module ilk_tag_pipe
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_vld,
    input  logic [1:0]                  in_cls,
    input  logic [REG_W-1:0]            in_dst,
    output logic [NTRK-1:0]             vld_o,
    output logic [NTRK-1:0][1:0]        cls_o,
    output logic [NTRK-1:0][REG_W-1:0]  dst_o
);

    typedef struct packed {
        logic [NTRK-1:0]            vld;
        logic [NTRK-1:0][1:0]       cls;
        logic [NTRK-1:0][REG_W-1:0] dst;
    } trk_t;

    trk_t trk_d, trk_q;

    // Index 0 is register read; every entry moves one stage per cycle
    always_comb begin
        trk_d     = trk_q;
        trk_d.vld = {trk_q.vld[NTRK-2:0], in_vld};
        trk_d.cls = {trk_q.cls[NTRK-2:0], in_cls};
        trk_d.dst = {trk_q.dst[NTRK-2:0], in_dst};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            trk_q <= '0;
        else
            trk_q <= trk_d;
    end

    assign vld_o = trk_q.vld;
    assign cls_o = trk_q.cls;
    assign dst_o = trk_q.dst;

    // R9: an entry leaving register read reaches the first ALU stage next cycle
    a_r9_advance: assert property (@(posedge clk) disable iff (!rst_n)
        trk_q.vld[0] |=> trk_q.vld[1]);

endmodule

// File: rtl/ilk_opnd_check.sv
module ilk_opnd_check
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                        byp,
    input  logic [REG_W-1:0]            src,
    input  logic [1:0]                  role,
    input  logic [NTRK-1:0]             vld_i,
    input  logic [NTRK-1:0][1:0]        cls_i,
    input  logic [NTRK-1:0][REG_W-1:0]  dst_i,
    output logic                        hold,
    output logic [2:0]                  fwd
);

    logic [NTRK-1:0] match;
    logic [NTRK-1:0] late;
    int              need;

    assign need = need_at(role, byp);

    for (genvar g = 0; g < NTRK; g++) begin : g_stage
        localparam int STG = ST_RR + g;
        assign match[g] = vld_i[g] && is_writer(cls_i[g]) && (role != RO_UNUSED)
                       && (src != '0) && (dst_i[g] == src);
        assign late[g]  = match[g] && ((STG + need - 1) < ready_at(cls_i[g], byp));
    end

    assign hold = |late;

    // Youngest match (lowest index) decides the source
    always_comb begin
        logic found;
        int   fut;
        found = 1'b0;
        fut   = 0;
        fwd   = 3'd0;
        for (int i = 0; i < NTRK; i++) begin
            if (match[i] && !found) begin
                found = 1'b1;
                fut   = ST_RR + i + need - 1;
                if (byp && (fut <= ST_RW))
                    fwd = 3'(fut);
            end
        end
    end

endmodule

// File: rtl/ilk_waw_check.sv
module ilk_waw_check
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic                        dec_wr,
    input  logic [REG_W-1:0]            dec_dst,
    input  logic [NTRK-1:0]             vld_i,
    input  logic [NTRK-1:0][1:0]        cls_i,
    input  logic [NTRK-1:0][REG_W-1:0]  dst_i,
    output logic                        hold
);

    logic [NTRK-1:0] hit;

    for (genvar g = 0; g < NTRK; g++) begin : g_stage
        localparam bit EARLY = (ST_RR + g) < WAW_CLEAR;
        assign hit[g] = EARLY && vld_i[g] && is_writer(cls_i[g]) && (dst_i[g] == dec_dst);
    end

    assign hold = dec_wr && (dec_dst != '0) && (|hit);

endmodule

// File: rtl/ilk_interlock.sv
module ilk_interlock
    import ilk_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bypass_en,
    input  logic             dec_valid,
    input  logic [1:0]       dec_class,
    input  logic [REG_W-1:0] dec_dst,
    input  logic [REG_W-1:0] src_a,
    input  logic [1:0]       role_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [1:0]       role_b,
    output logic             stall,
    output logic [2:0]       fwd_a,
    output logic [2:0]       fwd_b
);

    localparam int NOPND = 2;
    localparam int RUN_W = $clog2(MAX_RUN + 2);

    logic [NTRK-1:0]            t_vld;
    logic [NTRK-1:0][1:0]       t_cls;
    logic [NTRK-1:0][REG_W-1:0] t_dst;

    logic [NOPND-1:0][REG_W-1:0] o_src;
    logic [NOPND-1:0][1:0]       o_role;
    logic [NOPND-1:0]            o_hold;
    logic [NOPND-1:0][2:0]       o_fwd;
    logic                        waw_hold;
    logic                        issue;

    assign o_src  = {src_b, src_a};
    assign o_role = {role_b, role_a};

    for (genvar k = 0; k < NOPND; k++) begin : g_opnd
        ilk_opnd_check #(.REG_W(REG_W)) u_chk (
            .byp   (bypass_en),
            .src   (o_src[k]),
            .role  (o_role[k]),
            .vld_i (t_vld),
            .cls_i (t_cls),
            .dst_i (t_dst),
            .hold  (o_hold[k]),
            .fwd   (o_fwd[k])
        );
    end

    ilk_waw_check #(.REG_W(REG_W)) u_waw (
        .dec_wr  (is_writer(dec_class)),
        .dec_dst (dec_dst),
        .vld_i   (t_vld),
        .cls_i   (t_cls),
        .dst_i   (t_dst),
        .hold    (waw_hold)
    );

    assign stall = dec_valid && ((|o_hold) || waw_hold);
    assign issue = dec_valid && !stall;
    assign fwd_a = dec_valid ? o_fwd[0] : 3'd0;
    assign fwd_b = dec_valid ? o_fwd[1] : 3'd0;

    ilk_tag_pipe #(.REG_W(REG_W)) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_vld (issue),
        .in_cls (dec_class),
        .in_dst (dec_dst),
        .vld_o  (t_vld),
        .cls_o  (t_cls),
        .dst_o  (t_dst)
    );

    // Run length of consecutive stall cycles, kept for the bound check
    logic [RUN_W-1:0] run_d, run_q;

    always_comb begin
        run_d = run_q;
        if (!stall)
            run_d = '0;
        else if (run_q <= RUN_W'(MAX_RUN))
            run_d = run_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= '0;
        else
            run_q <= run_d;
    end

    // R9: a stall cycle sends an empty slot into register read
    a_r9_bubble: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !t_vld[0]);

    // R9: a leaving instruction appears in register read next cycle
    a_r9_issue: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> t_vld[0]);

    // R2: without forwarding, a writer of src_a in register read must hold decode
    a_r2_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass_en && dec_valid && (role_a != RO_UNUSED) && (src_a != '0)
         && t_vld[0] && is_writer(t_cls[0]) && (t_dst[0] == src_a)) |-> stall);

    // R6: register 0 everywhere never stalls
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && (src_a == '0) && (src_b == '0) && (dec_dst == '0)) |-> !stall);

    // R4: a forwarded value never comes from before the earliest ready stage
    a_r4_fwd_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && (fwd_a != 3'd0)) |-> (fwd_a >= 3'(ST_M1)));

    // R8: no dependence needs more slots than the distance to write-back allows
    a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(MAX_RUN));

endmodule

// File: tb/sim_ilk_interlock.sv
module sim_ilk_interlock;

    typedef struct packed {
        logic       v;
        logic [1:0] c;
        logic [4:0] d;
        logic [4:0] a;
        logic [1:0] ra;
        logic [4:0] b;
        logic [1:0] rb;
    } ins_t;

    typedef struct {
        int         bub;
        logic [2:0] fa;
        logic [2:0] fb;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byp = 1'b0;
    logic       dv = 1'b0;
    logic [1:0] dc = 2'd0;
    logic [4:0] dd = 5'd0, sa = 5'd0, sb = 5'd0;
    logic [1:0] ra = 2'd0, rb = 2'd0;
    logic       stall;
    logic [2:0] fwd_a, fwd_b;
    logic       chk_now = 1'b0;

    int   checks = 0;
    int   errors = 0;
    int   run = 0;
    exp_t q[$];

    always #10 clk = ~clk;

    ilk_interlock #(.REG_W(5)) u0 (
        .clk(clk), .rst_n(rst_n), .bypass_en(byp), .dec_valid(dv), .dec_class(dc),
        .dec_dst(dd), .src_a(sa), .role_a(ra), .src_b(sb), .role_b(rb),
        .stall(stall), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    function automatic ins_t alu(input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
        return '{v:1'b1, c:2'd1, d:d, a:a, ra:2'd1, b:b, rb:2'd1};
    endfunction
    function automatic ins_t ld(input logic [4:0] d, input logic [4:0] a);
        return '{v:1'b1, c:2'd2, d:d, a:a, ra:2'd1, b:5'd0, rb:2'd0};
    endfunction
    function automatic ins_t sd(input logic [4:0] data, input logic [4:0] addr);
        return '{v:1'b1, c:2'd3, d:5'd0, a:data, ra:2'd2, b:addr, rb:2'd3};
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Driver: present one instruction, wait until it leaves decode
    task automatic send(input ins_t i, input bit chk);
        dv = i.v; dc = i.c; dd = i.d; sa = i.a; ra = i.ra; sb = i.b; rb = i.rb;
        chk_now = chk;
        if (i.v) begin
            do @(negedge clk); while (stall);
        end else begin
            @(negedge clk);
        end
        @(posedge clk);
        #1;
        dv = 1'b0; chk_now = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 8; k++) send('0, 1'b0);
    endtask

    task automatic pair(input ins_t p, input ins_t c, input int bub,
                        input logic [2:0] fa, input logic [2:0] fb, input string tag);
        exp_t e;
        drain();
        send(p, 1'b0);
        e.bub = bub; e.fa = fa; e.fb = fb; e.tag = tag;
        q.push_back(e);
        send(c, 1'b1);
    endtask

    task automatic triple(input ins_t p1, input ins_t p2, input ins_t c, input int bub,
                          input logic [2:0] fa, input logic [2:0] fb, input string tag);
        exp_t e;
        drain();
        send(p1, 1'b0);
        send(p2, 1'b0);
        e.bub = bub; e.fa = fa; e.fb = fb; e.tag = tag;
        q.push_back(e);
        send(c, 1'b1);
    endtask

    // Monitor: count stall cycles, compare when the checked instruction leaves
    always @(negedge clk) begin
        if (rst_n && dv) begin
            if (stall) begin
                run++;
            end else begin
                if (chk_now) begin
                    if (q.size() == 0) begin
                        check("scoreboard", "unexpected issue", 1, 0);
                    end else begin
                        exp_t e;
                        e = q.pop_front();
                        check(e.tag, "empty slots", run, e.bub);
                        check(e.tag, "fwd_a", int'(fwd_a), int'(e.fa));
                        check(e.tag, "fwd_b", int'(fwd_b), int'(e.fb));
                    end
                end
                run = 0;
            end
        end
    end

    initial begin
        #(200000 * 20);
        check("watchdog", "run completed", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        ins_t st2;
        ins_t ldu;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check("R1", "stall idle", int'(stall), 0);
        check("R1", "fwd_a idle", int'(fwd_a), 0);
        // R1: dependent-looking decode with empty record
        @(posedge clk); #1;
        dv = 1'b1; dc = 2'd1; dd = 5'd4; sa = 5'd3; ra = 2'd1; sb = 5'd7; rb = 2'd1; byp = 1'b1;
        @(negedge clk);
        check("R1", "stall empty record", int'(stall), 0);
        check("R1", "fwd_b empty record", int'(fwd_b), 0);
        @(posedge clk); #1 dv = 1'b0;

        // Without forwarding
        byp = 1'b0;
        pair(alu(3, 1, 2), alu(5, 3, 4), 5, 3'd0, 3'd0, "R2");
        pair(ld(2, 1), alu(4, 2, 3), 5, 3'd0, 3'd0, "R2");
        pair(ld(2, 1), sd(2, 3), 5, 3'd0, 3'd0, "R2");
        pair(ld(2, 1), sd(3, 2), 5, 3'd0, 3'd0, "R2");
        triple(alu(3, 1, 2), alu(7, 8, 9), alu(5, 3, 4), 4, 3'd0, 3'd0, "R2");
        pair(alu(2, 1, 1), alu(2, 4, 5), 2, 3'd0, 3'd0, "R7");

        // With forwarding
        byp = 1'b1;
        pair(alu(3, 1, 2), alu(5, 3, 4), 1, 3'd5, 3'd0, "R3");
        pair(alu(3, 1, 2), alu(5, 4, 3), 1, 3'd0, 3'd5, "R3");
        pair(ld(2, 1), alu(4, 2, 3), 3, 3'd7, 3'd0, "R4");
        pair(ld(2, 1), sd(2, 3), 3, 3'd7, 3'd0, "R4");
        pair(ld(2, 1), sd(3, 2), 1, 3'd0, 3'd7, "R5");
        pair(alu(2, 1, 1), sd(3, 2), 0, 3'd0, 3'd6, "R5");
        pair(alu(0, 1, 2), alu(5, 0, 0), 0, 3'd0, 3'd0, "R6");
        st2 = sd(4, 6); st2.d = 5'd2;
        pair(st2, alu(5, 2, 3), 0, 3'd0, 3'd0, "R6");
        ldu = ld(6, 4); ldu.b = 5'd2;
        pair(ld(2, 1), ldu, 0, 3'd0, 3'd0, "R6");
        pair(alu(2, 1, 1), alu(2, 4, 5), 2, 3'd0, 3'd0, "R7");
        triple(ld(2, 1), alu(6, 7, 8), alu(9, 6, 2), 2, 3'd6, 3'd7, "R8 R9");
        drain();

        check("scoreboard", "pending items", q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule